// File: doc/BRIEF.md
# SIMD Divergence Mask Controller

This block keeps the active-lane mask for a group of lanes that share one instruction stream. The sequencer presents one control opcode per cycle together with a per-lane condition vector from the ALUs. The block answers in the same cycle with `skip` (jump forward to the matching else, endif or loop end, because no lane needs the next stretch of code) and `loop_back` (branch to the loop top, because some lane is still iterating). It then updates `exec_mask` at the next clock edge. The mask governs which lanes the following instructions write.

Nesting state lives in a stack of frames. An if frame holds the mask in force on entry and the mask the else side will use. A loop frame holds the entry mask. If all active lanes agree on an if condition, only one side runs and the other is skipped. If they disagree, both sides run in turn. A loop keeps iterating until its last lane has dropped out.

A small state machine tracks stack misuse. It starts in CLEAN after reset. It moves from CLEAN to FAULTED on any fault event: a push onto a full stack, a pop of an empty stack, or a frame-kind mismatch. It stays in FAULTED until reset. `stack_err` is high in FAULTED.

Opcode encoding on `op_code`: 0 no-op, 1 IF, 2 ELSE, 3 ENDIF, 4 LOOP_BEGIN, 5 LOOP_TEST, 6 LOOP_END, 7 reserved (treated as no-op).

Top module: `lane_mask_ctrl`

## Requirements
- R1: After reset `exec_mask` is all ones, `stack_err` is 0 and the stack is empty. An ENDIF as the first opcode therefore faults.
- R2: IF (code 1) sets the mask to `exec_mask & cond` at the next edge and pushes an if frame.
- R3: IF raises `skip` in its own cycle exactly when `exec_mask & cond` is zero.
- R4: ELSE (code 2) sets the mask to entry mask AND NOT the IF condition. `skip` is raised in the same cycle when that value is zero. Lanes inactive before the IF stay inactive.
- R5: ENDIF (code 3) pops the if frame and restores the mask that was in force before the IF.
- R6: When active lanes disagree at an IF, neither the IF nor the ELSE raises `skip`, and both sides get a nonzero mask.
- R7: LOOP_BEGIN (code 4) pushes a loop frame and leaves the mask unchanged. It raises `skip` when the current mask is zero.
- R8: LOOP_TEST (code 5) sets the mask to `exec_mask & cond` without touching the stack. It raises `skip` when the result is zero.
- R9: LOOP_END (code 6) with a nonzero mask raises `loop_back` and holds the mask. With a zero mask it pops the loop frame, restores the entry mask and leaves `loop_back` low.
- R10: The stack holds 8 frames. A ninth push sets `stack_err`, keeps the mask, raises no `skip` and stores nothing, so the next pop restores the eighth frame.
- R11: ELSE, ENDIF or LOOP_END on an empty stack sets `stack_err` and leaves the mask unchanged.
- R12: ELSE or ENDIF with a loop frame on top, or LOOP_END with an if frame on top, sets `stack_err` and changes neither mask nor stack.
- R13: `stack_err` stays set until reset.
- R14: Codes 0 and 7 change nothing, whatever `cond` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Control opcode for this cycle |
| cond | input | 16 | Per-lane condition, 1 = true |
| exec_mask | output | 16 | Active-lane mask, 1 = lane active |
| skip | output | 1 | Same-cycle request to jump to the matching else/endif/loop end |
| loop_back | output | 1 | Same-cycle request to branch back to the loop top |
| stack_err | output | 1 | Sticky stack misuse flag |

## Verification
The assertions check four properties on every cycle:
- IF and LOOP_TEST only ever clear mask bits, and ENDIF only ever sets them.
- No-ops, faults and loop-back cycles leave the mask alone.
- `skip` comes only from opcodes that can skip.
- The stack is never asked to push when full or pop when empty, and the error flag never drops.

The exact mask values cannot be shown by these properties and need the bench's scenarios. These cover the inverted else mask, uniform versus divergent branches, loop iterations that shed lanes down to the exit, eight-deep nesting with overflow, and the frame-kind mismatches.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_IF     = 3'd1,
        OP_ELSE   = 3'd2,
        OP_ENDIF  = 3'd3,
        OP_LBEGIN = 3'd4,
        OP_LTEST  = 3'd5,
        OP_LEND   = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FAULTED = 1'b1
    } err_state_e;

endpackage

// File: rtl/lmc_stack.sv
module lmc_stack #(
    parameter int LANES = 16,
    parameter int DEPTH = 8,
    localparam int FW   = 2 * LANES + 1,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [FW-1:0] push_frame,
    output logic [FW-1:0] top_frame,
    output logic          full,
    output logic          empty
);

    logic [FW-1:0] frames [DEPTH];
    logic [PW-1:0] ptr;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] top_idx;

    assign wr_idx    = ptr[IW-1:0];
    assign top_idx   = IW'(ptr - 1'b1);
    assign full      = (ptr == PW'(DEPTH));
    assign empty     = (ptr == '0);
    assign top_frame = frames[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                frames[i] <= '0;
            end
        end else if (push) begin
            frames[wr_idx] <= push_frame;
            ptr            <= ptr + 1'b1;
        end else if (pop) begin
            ptr <= ptr - 1'b1;
        end
    end

    // R10
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R11
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R12
    no_push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/lmc_decide.sv
module lmc_decide
    import lmc_pkg::*;
#(
    parameter int LANES = 16,
    localparam int FW   = 2 * LANES + 1
) (
    input  logic [2:0]       op_code,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] mask,
    input  logic [FW-1:0]    top_frame,
    input  logic             full,
    input  logic             empty,
    output logic [LANES-1:0] nxt_mask,
    output logic             push,
    output logic             pop,
    output logic [FW-1:0]    push_frame,
    output logic             skip,
    output logic             loop_back,
    output logic             fault
);

    op_e              opc;
    logic [LANES-1:0] taken;
    logic [LANES-1:0] top_entry;
    logic [LANES-1:0] top_alt;
    logic             top_loop;

    assign opc       = op_e'(op_code);
    assign taken     = mask & cond;
    assign top_entry = top_frame[LANES-1:0];
    assign top_alt   = top_frame[2*LANES-1:LANES];
    assign top_loop  = top_frame[FW-1];

    always_comb begin
        nxt_mask   = mask;
        push       = 1'b0;
        pop        = 1'b0;
        push_frame = '0;
        skip       = 1'b0;
        loop_back  = 1'b0;
        fault      = 1'b0;
        unique case (opc)
            OP_IF: begin
                if (full) begin
                    fault = 1'b1;
                end else begin
                    push       = 1'b1;
                    push_frame = {1'b0, mask & ~cond, mask};
                    nxt_mask   = taken;
                    skip       = (taken == '0);
                end
            end
            OP_ELSE: begin
                if (empty || top_loop) begin
                    fault = 1'b1;
                end else begin
                    nxt_mask = top_alt;
                    skip     = (top_alt == '0);
                end
            end
            OP_ENDIF: begin
                if (empty || top_loop) begin
                    fault = 1'b1;
                end else begin
                    pop      = 1'b1;
                    nxt_mask = top_entry;
                end
            end
            OP_LBEGIN: begin
                if (full) begin
                    fault = 1'b1;
                end else begin
                    push       = 1'b1;
                    push_frame = {1'b1, {LANES{1'b0}}, mask};
                    skip       = (mask == '0);
                end
            end
            OP_LTEST: begin
                nxt_mask = taken;
                skip     = (taken == '0);
            end
            OP_LEND: begin
                if (empty || !top_loop) begin
                    fault = 1'b1;
                end else if (mask != '0) begin
                    loop_back = 1'b1;
                end else begin
                    pop      = 1'b1;
                    nxt_mask = top_entry;
                end
            end
            OP_NOP, OP_RSVD: begin
            end
        endcase
    end

endmodule

// File: rtl/lmc_fsm.sv
module lmc_fsm
    import lmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_evt,
    output logic err
);

    err_state_e state;
    err_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CLEAN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        err       = 1'b0;
        unique case (state)
            ST_CLEAN: begin
                if (fault_evt) begin
                    state_nxt = ST_FAULTED;
                end
            end
            ST_FAULTED: begin
                err = 1'b1;
            end
        endcase
    end

    // R13
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R13
    err_follows_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> err);

endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
    import lmc_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DEPTH = 8,
    localparam int FW   = 2 * LANES + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_code,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] exec_mask,
    output logic             skip,
    output logic             loop_back,
    output logic             stack_err
);

    logic [LANES-1:0] nxt_mask;
    logic             push;
    logic             pop;
    logic [FW-1:0]    push_frame;
    logic [FW-1:0]    top_frame;
    logic             full;
    logic             empty;
    logic             fault_evt;

    lmc_decide #(.LANES(LANES)) u_decide (
        .op_code    (op_code),
        .cond       (cond),
        .mask       (exec_mask),
        .top_frame  (top_frame),
        .full       (full),
        .empty      (empty),
        .nxt_mask   (nxt_mask),
        .push       (push),
        .pop        (pop),
        .push_frame (push_frame),
        .skip       (skip),
        .loop_back  (loop_back),
        .fault      (fault_evt)
    );

    lmc_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .push_frame (push_frame),
        .top_frame  (top_frame),
        .full       (full),
        .empty      (empty)
    );

    lmc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_evt (fault_evt),
        .err       (stack_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_mask <= '1;
        end else begin
            exec_mask <= nxt_mask;
        end
    end

    // R14
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_NOP || op_code == OP_RSVD) |=> $stable(exec_mask));

    // R2
    if_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_IF) |=> ((exec_mask & ~$past(exec_mask)) == '0));

    // R8
    ltest_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_LTEST) |=> ((exec_mask & ~$past(exec_mask)) == '0));

    // R5
    endif_widens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_ENDIF) |=> ((~exec_mask & $past(exec_mask)) == '0));

    // R9
    loop_back_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_back |=> $stable(exec_mask));

    // R11
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> $stable(exec_mask));

    // R3
    skip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (op_code == OP_IF || op_code == OP_ELSE ||
                  op_code == OP_LBEGIN || op_code == OP_LTEST));

    // R9
    one_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip && loop_back));

endmodule

// File: tb/lane_mask_ctrl_test.sv
module lane_mask_ctrl_test;
    import lmc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = OP_NOP;
    logic [15:0] cond = '0;
    logic [15:0] exec_mask;
    logic        skip;
    logic        loop_back;
    logic        stack_err;

    int checks = 0;
    int errors = 0;
    logic s_skip;
    logic s_back;

    always #4 clk = ~clk;

    lane_mask_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .cond      (cond),
        .exec_mask (exec_mask),
        .skip      (skip),
        .loop_back (loop_back),
        .stack_err (stack_err)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        op_code = OP_NOP;
        cond    = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic issue(input logic [2:0] o, input logic [15:0] c);
        @(negedge clk);
        op_code = o;
        cond    = c;
        #1;
        s_skip = skip;
        s_back = loop_back;
        @(posedge clk);
        #1;
        op_code = OP_NOP;
        cond    = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mask", exec_mask, 16'hFFFF);
        chk("R1 err", {15'd0, stack_err}, 16'd0);
        chk("R1 skip", {15'd0, skip}, 16'd0);
    endtask

    task automatic t_nop();
        issue(OP_NOP, 16'h1234);
        chk("R14 nop0", exec_mask, 16'hFFFF);
        issue(OP_RSVD, 16'h0000);
        chk("R14 nop7", exec_mask, 16'hFFFF);
        chk("R14 skip", {15'd0, s_skip}, 16'd0);
    endtask

    task automatic t_divergent();
        issue(OP_IF, 16'h00FF);
        chk("R6 if skip", {15'd0, s_skip}, 16'd0);
        chk("R2 if mask", exec_mask, 16'h00FF);
        issue(OP_ELSE, 16'h0000);
        chk("R6 else skip", {15'd0, s_skip}, 16'd0);
        chk("R4 else mask", exec_mask, 16'hFF00);
        issue(OP_ENDIF, 16'h0000);
        chk("R5 endif mask", exec_mask, 16'hFFFF);
        chk("R11 no err", {15'd0, stack_err}, 16'd0);
    endtask

    task automatic t_nested_uniform();
        issue(OP_IF, 16'h0F0F);
        chk("R2 outer", exec_mask, 16'h0F0F);
        issue(OP_IF, 16'hF0F0);
        chk("R3 all false skip", {15'd0, s_skip}, 16'd1);
        chk("R2 inner zero", exec_mask, 16'h0000);
        issue(OP_ELSE, 16'h0000);
        chk("R4 inner else skip", {15'd0, s_skip}, 16'd0);
        chk("R4 inner else mask", exec_mask, 16'h0F0F);
        issue(OP_ENDIF, 16'h0000);
        chk("R5 inner endif", exec_mask, 16'h0F0F);
        issue(OP_ELSE, 16'h0000);
        chk("R4 outer else", exec_mask, 16'hF0F0);
        issue(OP_IF, 16'hFFFF);
        chk("R3 all true no skip", {15'd0, s_skip}, 16'd0);
        chk("R4 entry kept", exec_mask, 16'hF0F0);
        issue(OP_ELSE, 16'h0000);
        chk("R4 empty else skip", {15'd0, s_skip}, 16'd1);
        chk("R4 empty else mask", exec_mask, 16'h0000);
        issue(OP_ENDIF, 16'h0000);
        chk("R5 restore", exec_mask, 16'hF0F0);
        issue(OP_ENDIF, 16'h0000);
        chk("R5 restore top", exec_mask, 16'hFFFF);
    endtask

    task automatic t_loop();
        issue(OP_LBEGIN, 16'h0000);
        chk("R7 begin skip", {15'd0, s_skip}, 16'd0);
        chk("R7 begin mask", exec_mask, 16'hFFFF);
        issue(OP_LTEST, 16'hFFF0);
        chk("R8 test1", exec_mask, 16'hFFF0);
        issue(OP_LEND, 16'h0000);
        chk("R9 back1", {15'd0, s_back}, 16'd1);
        chk("R9 hold1", exec_mask, 16'hFFF0);
        issue(OP_LTEST, 16'h0F0F);
        chk("R8 test2", exec_mask, 16'h0F00);
        chk("R8 no skip", {15'd0, s_skip}, 16'd0);
        issue(OP_LEND, 16'h0000);
        chk("R9 back2", {15'd0, s_back}, 16'd1);
        issue(OP_LTEST, 16'h00FF);
        chk("R8 exit skip", {15'd0, s_skip}, 16'd1);
        chk("R8 exit mask", exec_mask, 16'h0000);
        issue(OP_LEND, 16'h0000);
        chk("R9 no back", {15'd0, s_back}, 16'd0);
        chk("R9 restore", exec_mask, 16'hFFFF);
        issue(OP_IF, 16'h0000);
        issue(OP_LBEGIN, 16'h0000);
        chk("R7 zero skip", {15'd0, s_skip}, 16'd1);
        chk("R7 zero mask", exec_mask, 16'h0000);
        issue(OP_LEND, 16'h0000);
        chk("R9 zero pop", exec_mask, 16'h0000);
        issue(OP_ENDIF, 16'h0000);
        chk("R5 after loop", exec_mask, 16'hFFFF);
        chk("R12 no err", {15'd0, stack_err}, 16'd0);
    endtask

    task automatic t_mismatch();
        do_reset();
        issue(OP_LBEGIN, 16'h0000);
        issue(OP_ELSE, 16'h0000);
        chk("R12 else on loop err", {15'd0, stack_err}, 16'd1);
        chk("R12 else on loop mask", exec_mask, 16'hFFFF);
        do_reset();
        issue(OP_IF, 16'h00FF);
        issue(OP_LEND, 16'h0000);
        chk("R12 lend on if err", {15'd0, stack_err}, 16'd1);
        chk("R12 lend on if back", {15'd0, s_back}, 16'd0);
        chk("R12 lend on if mask", exec_mask, 16'h00FF);
        issue(OP_ENDIF, 16'h0000);
        chk("R12 frame kept", exec_mask, 16'hFFFF);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            issue(OP_IF, ~(16'h0001 << i));
        end
        chk("R10 eight deep", exec_mask, 16'hFF00);
        chk("R10 no err yet", {15'd0, stack_err}, 16'd0);
        issue(OP_IF, 16'h0000);
        chk("R10 overflow err", {15'd0, stack_err}, 16'd1);
        chk("R10 overflow skip", {15'd0, s_skip}, 16'd0);
        chk("R10 overflow mask", exec_mask, 16'hFF00);
        issue(OP_ENDIF, 16'h0000);
        chk("R10 eighth frame", exec_mask, 16'hFF80);
        for (int i = 0; i < 7; i++) begin
            issue(OP_ENDIF, 16'h0000);
        end
        chk("R10 unwound", exec_mask, 16'hFFFF);
        chk("R13 still err", {15'd0, stack_err}, 16'd1);
    endtask

    task automatic t_underflow();
        do_reset();
        chk("R13 reset clears", {15'd0, stack_err}, 16'd0);
        issue(OP_IF, 16'h000F);
        issue(OP_ENDIF, 16'h0000);
        issue(OP_ENDIF, 16'h0000);
        chk("R11 endif empty err", {15'd0, stack_err}, 16'd1);
        chk("R11 endif empty mask", exec_mask, 16'hFFFF);
        issue(OP_LTEST, 16'h00F0);
        issue(OP_ELSE, 16'h0000);
        chk("R11 else empty mask", exec_mask, 16'h00F0);
        issue(OP_LEND, 16'h0000);
        chk("R11 lend empty back", {15'd0, s_back}, 16'd0);
        chk("R11 lend empty mask", exec_mask, 16'h00F0);
        issue(OP_NOP, 16'h0000);
        chk("R13 sticky", {15'd0, stack_err}, 16'd1);
    endtask

    initial begin
        t_reset();
        t_nop();
        t_divergent();
        t_nested_uniform();
        t_loop();
        t_mismatch();
        t_overflow();
        t_underflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule